// File: doc/BRIEF.md
# Single-CPU Interrupt Distributor and CPU Interface

This block gathers interrupt requests for one processor and decides which one that processor should take next. It holds 64 sources. IDs 0 to 15 are raised only by software. IDs 16 to 63 follow level inputs from the rest of the chip. For each source the block keeps an enable bit, a pending bit, an active bit and an 8-bit priority. All of this state sits behind one 32-bit register bus, which has a distributor region and a CPU-interface region.

Software runs the usual handshake. A read of the acknowledge register returns the winning source and marks it active. A write of the same ID to the end-of-interrupt register finishes it. When nothing can be signalled, the acknowledge read returns a reserved spurious ID. While one source is being serviced, a source with a strictly lower priority value can still interrupt it. This is tracked through a running priority. Software can also raise IDs 0 to 15 through a trigger register.

Top module: `gic_lite`

## Requirements
- R1: After reset the following hold:
  - All enable, pending and active bits are 0.
  - Both control bits are 0 and the priority mask is 0.
  - `cpu_irq` is low, the running priority reads 0xFF and the highest-pending register reads 0x3FF.
- R2: Bus addressing works as follows:
  - Address bit 12 selects the CPU-interface region (1) or the distributor region (0). Bits [11:0] are the byte offset, and only word-aligned accesses take effect.
  - Read data appears on `bus_rdata` after the clock edge that samples `bus_rd`.
  - Distributor 0x004 reads the value NSRC/32−1 in bits [4:0], which is 1 for 64 sources.
  - CPU 0xFC reads the parameter `IFACE_ID`.
  - The words at 0x800+4n read 0x01010101 (every source targets CPU 0).
- R3: Enable bits work as follows:
  - Writing 1 to bit b of distributor word 0x100+4w enables source 32w+b.
  - Writing 1 to bit b of word 0x180+4w disables that source.
  - Zero bits have no effect.
  - Both addresses read back the current enable word.
- R4: Pending bits work as follows:
  - Source 16+k becomes pending at every clock edge where `src_level[k]` is high.
  - A 1 written to 0x200+4w sets pending bits, and a 1 written to 0x280+4w clears them. Both addresses read the pending word.
  - A clear does not hold while the level input is still high.
- R5: Each source has an 8-bit priority. Source 4n+j lies in bits [8j+7:8j] of distributor word 0x400+4n, and the word reads back as written.
- R6: A source is a candidate when it is enabled, pending and not active. Among candidates, the lowest priority value wins, and a tie goes to the lowest ID. CPU 0x18 reads the winning ID, or 0x3FF when there is no candidate.
- R7: A source is forwarded only when bit 0 of distributor 0x000 and bit 0 of CPU 0x00 are both 1. Otherwise the acknowledge register returns 0x3FF and `cpu_irq` stays low.
- R8: The winner is forwarded only if its priority is numerically below the mask held in CPU 0x04 bits [7:0].
- R9: A read of CPU 0x0C behaves as follows:
  - If a source can be forwarded, the read returns its ID in bits [9:0] with the upper bits 0, clears its pending bit and sets its active bit.
  - Otherwise the read returns 0x3FF and changes no state.
  - Active bits read at distributor 0x300+4w.
- R10: A write to CPU 0x10 clears the active bit of the ID in bits [9:0]. IDs of 64 or more have no effect.
- R11: CPU 0x14 reads the lowest priority value among active sources, or 0xFF when none is active. The winner is forwarded only if its priority is numerically below that running priority.
- R12: `cpu_irq` is registered. It shows, one clock edge later, whether an acknowledge read would return a real ID.
- R13: A write to distributor 0xF00 with bit 16 set makes source `wdata[3:0]` pending. With bit 16 clear the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 13 | Byte address; bit 12 selects the CPU interface |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_level | input | NSRC−NSGI | Level requests for IDs 16 and up |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The in-module properties run on every cycle and check the following:
- A raised `cpu_irq` is always preceded by both enables, by a winner below the running priority, and by the mask test.
- A spurious acknowledge leaves the active set untouched.
- A real acknowledge adds exactly one active bit.
- End-of-interrupt clears the named bit.
- Set-enable and level inputs take effect on the next edge.

Only the bench's scenarios can show the choices between sources. These are:
- tie-breaking by ID;
- nesting by running priority;
- masking at the exact boundary value;
- the ID returned by acknowledge;
- SGI targeting;
- the long random mix of writes, level changes, acknowledges and completions, compared against a bench model of the state.

// File: rtl/gic_lite.sv
`timescale 1ns/1ps
module gic_lite #(
  parameter int NSRC = 64,
  parameter int NSGI = 16,
  parameter logic [31:0] IFACE_ID = 32'h0102_043B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [12:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NSRC-NSGI-1:0] src_level,
  output logic                 cpu_irq
);
  localparam int NWORD = NSRC / 32;
  localparam int NPW   = NSRC / 4;
  localparam int IDW   = 10;
  localparam int SGW   = $clog2(NSGI);
  localparam logic [IDW-1:0] SPUR = '1;
  localparam logic [4:0] TYPE_N = 5'(NWORD - 1);
  localparam int B_SEN = 'h40, B_CEN = 'h60, B_SPN = 'h80, B_CPN = 'hA0, B_ACT = 'hC0;
  localparam int B_PRI = 'h100, B_TGT = 'h200, B_SGI = 'h3C0;

  logic is_cpu, aligned, dwr, cwr, ack_rd, eoi_wr, sgi_wr;
  logic [9:0] wsel;
  assign is_cpu  = bus_addr[12];
  assign aligned = bus_addr[1:0] == 2'b00;
  assign wsel    = bus_addr[11:2];
  assign dwr     = bus_wr & ~is_cpu & aligned;
  assign cwr     = bus_wr & is_cpu & aligned;
  assign ack_rd  = bus_rd & is_cpu & aligned & (wsel == 10'h003);
  assign eoi_wr  = cwr & (wsel == 10'h004);
  assign sgi_wr  = dwr & (wsel == 10'(B_SGI)) & bus_wdata[16];

  logic dist_en, cpu_en, irq_q;
  logic [7:0] pmask;
  logic [NSRC-1:0] en_q, pend_q, act_q;
  logic [7:0] prio_q [NSRC];
  logic [31:0] rdata_q, rd_val;

  logic [NSRC-1:0] cand;
  logic best_ok, present, ack_take;
  logic [IDW-1:0] best_id;
  logic [7:0] best_pr, run_pr;
  assign cand = en_q & pend_q & ~act_q;

  always_comb begin
    best_ok = 1'b0;
    best_id = SPUR;
    best_pr = 8'hFF;
    run_pr  = 8'hFF;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!best_ok || prio_q[i] < best_pr)) begin
        best_ok = 1'b1;
        best_id = IDW'(i);
        best_pr = prio_q[i];
      end
      if (act_q[i] && prio_q[i] < run_pr) run_pr = prio_q[i];
    end
  end

  assign present  = dist_en & cpu_en & best_ok & (best_pr < pmask) & (best_pr < run_pr);
  assign ack_take = ack_rd & present;

  logic [NSRC-1:0] sen_mask, cen_mask, spn_mask, cpn_mask, eoi_hit;
  logic [NSRC-1:0] en_d, pend_d, act_d;
  always_comb begin
    for (int w = 0; w < NWORD; w++) begin
      sen_mask[w*32 +: 32] = (dwr && wsel == 10'(B_SEN + w)) ? bus_wdata : 32'h0;
      cen_mask[w*32 +: 32] = (dwr && wsel == 10'(B_CEN + w)) ? bus_wdata : 32'h0;
      spn_mask[w*32 +: 32] = (dwr && wsel == 10'(B_SPN + w)) ? bus_wdata : 32'h0;
      cpn_mask[w*32 +: 32] = (dwr && wsel == 10'(B_CPN + w)) ? bus_wdata : 32'h0;
    end
    for (int i = 0; i < NSRC; i++)
      eoi_hit[i] = eoi_wr && bus_wdata[IDW-1:0] == IDW'(i);
  end

  always_comb begin
    en_d   = (en_q | sen_mask) & ~cen_mask;
    pend_d = (pend_q | spn_mask) & ~cpn_mask;
    act_d  = act_q & ~eoi_hit;
    for (int i = 0; i < NSGI; i++)
      if (sgi_wr && bus_wdata[SGW-1:0] == SGW'(i)) pend_d[i] = 1'b1;
    for (int i = 0; i < NSRC; i++)
      if (ack_take && best_id == IDW'(i)) begin
        pend_d[i] = 1'b0;
        act_d[i]  = 1'b1;
      end
    pend_d[NSRC-1:NSGI] = pend_d[NSRC-1:NSGI] | src_level;
  end

  always_comb begin
    rd_val = 32'h0;
    if (aligned && is_cpu) begin
      case (wsel)
        10'h000: rd_val = {31'h0, cpu_en};
        10'h001: rd_val = {24'h0, pmask};
        10'h003: rd_val = {22'h0, present ? best_id : SPUR};
        10'h005: rd_val = {24'h0, run_pr};
        10'h006: rd_val = {22'h0, best_id};
        10'h03F: rd_val = IFACE_ID;
        default: rd_val = 32'h0;
      endcase
    end else if (aligned) begin
      if (wsel == 10'h000) rd_val = {31'h0, dist_en};
      if (wsel == 10'h001) rd_val = {27'h0, TYPE_N};
      for (int w = 0; w < NWORD; w++) begin
        if (wsel == 10'(B_SEN + w) || wsel == 10'(B_CEN + w)) rd_val = en_q[w*32 +: 32];
        if (wsel == 10'(B_SPN + w) || wsel == 10'(B_CPN + w)) rd_val = pend_q[w*32 +: 32];
        if (wsel == 10'(B_ACT + w)) rd_val = act_q[w*32 +: 32];
      end
      for (int p = 0; p < NPW; p++) begin
        if (wsel == 10'(B_PRI + p))
          rd_val = {prio_q[4*p+3], prio_q[4*p+2], prio_q[4*p+1], prio_q[4*p]};
        if (wsel == 10'(B_TGT + p)) rd_val = 32'h0101_0101;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      cpu_en  <= 1'b0;
      pmask   <= 8'h00;
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= 32'h0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= 8'h00;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      irq_q  <= present;
      if (dwr && wsel == 10'h000) dist_en <= bus_wdata[0];
      if (cwr && wsel == 10'h000) cpu_en <= bus_wdata[0];
      if (cwr && wsel == 10'h001) pmask <= bus_wdata[7:0];
      for (int i = 0; i < NSRC; i++)
        if (dwr && wsel == 10'(B_PRI + i / 4)) prio_q[i] <= bus_wdata[8*(i%4) +: 8];
      if (bus_rd) rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign cpu_irq   = irq_q;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(dist_en && cpu_en));

  // R11
  irq_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(best_pr < run_pr && best_pr < pmask));

  // R9
  spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !present && !bus_wr) |=> (bus_rdata == {22'h0, SPUR}) && $stable(act_q));

  // R9
  ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !bus_wr) |=> (bus_rdata[IDW-1:0] != SPUR) &&
      ($countones(act_q) == $countones($past(act_q)) + 1));

  // R10
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !bus_rd) |=> ((act_q & $past(eoi_hit)) == '0));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sen_mask) |=> ((en_q & $past(sen_mask)) == $past(sen_mask)) &&
      (((en_q ^ $past(en_q)) & ~$past(sen_mask)) == '0));

  // R4
  lvl_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_level) |=> ((pend_q[NSRC-1:NSGI] & $past(src_level)) == $past(src_level)));
endmodule

// File: tb/sim_gic_lite.sv
`timescale 1ns/1ps
module sim_gic_lite;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [47:0] lvl = '0;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [12:0] C = 13'h1000;
  localparam logic [12:0] ACK = C | 13'h00C, EOI = C | 13'h010, RPR = C | 13'h014;
  localparam logic [12:0] HPP = C | 13'h018, PMR = C | 13'h004;

  always #2.5 clk = ~clk;

  gic_lite u0 (.clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
               .bus_wdata(wdata), .bus_rdata(rdata), .src_level(lvl), .cpu_irq(irq));

  logic [63:0] m_en = '0, m_pend = '0, m_act = '0;
  logic [7:0] m_pri [64];
  logic m_den = 1'b0, m_cen = 1'b0;
  logic [7:0] m_pmr = 8'h00;

  function automatic logic [9:0] f_best();
    logic [63:0] c = m_en & m_pend & ~m_act;
    logic [9:0] id = 10'h3FF;
    logic [7:0] bp = 8'hFF;
    logic ok = 1'b0;
    for (int i = 0; i < 64; i++)
      if (c[i] && (!ok || m_pri[i] < bp)) begin ok = 1'b1; id = 10'(i); bp = m_pri[i]; end
    return id;
  endfunction

  function automatic logic [7:0] f_run();
    logic [7:0] r = 8'hFF;
    for (int i = 0; i < 64; i++) if (m_act[i] && m_pri[i] < r) r = m_pri[i];
    return r;
  endfunction

  function automatic logic f_present();
    logic [9:0] id = f_best();
    if (!(m_den && m_cen) || id == 10'h3FF) return 1'b0;
    return (m_pri[id[5:0]] < m_pmr) && (m_pri[id[5:0]] < f_run());
  endfunction

  function automatic logic [9:0] f_ack();
    return f_present() ? f_best() : 10'h3FF;
  endfunction

  task automatic m_write(input logic [12:0] a, input logic [31:0] d);
    int w;
    if (a[12]) begin
      if (a[11:0] == 12'h000) m_cen = d[0];
      if (a[11:0] == 12'h004) m_pmr = d[7:0];
      if (a[11:0] == 12'h010 && d[9:0] < 10'd64) m_act[d[5:0]] = 1'b0;
    end else begin
      w = int'(a[2]);
      if (a[11:0] == 12'h000) m_den = d[0];
      if (a[11:3] == 9'h020) m_en[w*32 +: 32] = m_en[w*32 +: 32] | d;
      if (a[11:3] == 9'h030) m_en[w*32 +: 32] = m_en[w*32 +: 32] & ~d;
      if (a[11:3] == 9'h040) m_pend[w*32 +: 32] = m_pend[w*32 +: 32] | d;
      if (a[11:3] == 9'h050) m_pend[w*32 +: 32] = m_pend[w*32 +: 32] & ~d;
      if (a[11:6] == 6'h10) begin
        w = int'(a[5:2]);
        for (int j = 0; j < 4; j++) m_pri[4*w+j] = d[8*j +: 8];
      end
      if (a[11:0] == 12'hF00 && d[16]) m_pend[d[3:0]] = 1'b1;
    end
  endtask

  task automatic idle();
    @(posedge clk);
    m_pend = m_pend | {lvl, 16'h0};
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    m_write(a, d);
    m_pend = m_pend | {lvl, 16'h0};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [31:0] q);
    logic [9:0] id;
    id = f_ack();
    rd = 1'b1; addr = a;
    @(posedge clk);
    if (a == ACK && id != 10'h3FF) begin m_pend[id[5:0]] = 1'b0; m_act[id[5:0]] = 1'b1; end
    m_pend = m_pend | {lvl, 16'h0};
    @(negedge clk);
    rd = 1'b0;
    q = rdata;
  endtask

  task automatic set_lvl(input logic [47:0] v);
    lvl = v;
    idle();
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input string what, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] q;
    bus_read(a, q);
    chk(req, what, q, exp);
  endtask

  task automatic ack_chk(input string req, input logic [31:0] exp_dir);
    logic [31:0] q, e;
    e = {22'h0, f_ack()};
    bus_read(ACK, q);
    chk(req, "ack vs model", q, e);
    chk(req, "ack directed", q, exp_dir);
  endtask

  task automatic state_chk(input string req);
    logic [31:0] q;
    bus_read(HPP, q);
    chk(req, "highest pending", q, {22'h0, f_best()});
    bus_read(RPR, q);
    chk(req, "running priority", q, {24'h0, f_run()});
    idle();
    chk(req, "cpu_irq", {31'h0, irq}, {31'h0, f_present()});
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, e;
    void'($urandom(32'd5147));
    for (int i = 0; i < 64; i++) m_pri[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "cpu_irq", {31'h0, irq}, 32'h0);
    rd_chk("R1", "enable word0", 13'h100, 32'h0);
    rd_chk("R1", "pending word1", 13'h204, 32'h0);
    rd_chk("R1", "active word0", 13'h300, 32'h0);
    rd_chk("R1", "running prio", RPR, 32'hFF);
    rd_chk("R1", "highest pending", HPP, 32'h3FF);
    rd_chk("R1", "pmask", PMR, 32'h0);
    ack_chk("R1", 32'h3FF);

    // R2 identification and addressing
    rd_chk("R2", "type", 13'h004, 32'h1);
    rd_chk("R2", "iface id", C | 13'h0FC, 32'h0102_043B);
    rd_chk("R2", "targets", 13'h814, 32'h0101_0101);
    rd_chk("R2", "config", 13'hC04, 32'h0);

    // R3 enables
    bus_write(13'h100, 32'h0000_F0F0);
    rd_chk("R3", "set enable", 13'h100, 32'h0000_F0F0);
    bus_write(13'h180, 32'h0000_00F0);
    rd_chk("R3", "clear enable", 13'h180, 32'h0000_F000);
    bus_write(13'h100, 32'h0);
    rd_chk("R3", "zero write", 13'h100, 32'h0000_F000);
    bus_write(13'h104, 32'h8000_0001);
    rd_chk("R3", "word1", 13'h104, 32'h8000_0001);

    // R5 priority packing
    bus_write(13'h428, 32'h1122_3344);
    rd_chk("R5", "prio word", 13'h428, 32'h1122_3344);

    // R4 levels and pending registers
    set_lvl(48'h10);
    rd_chk("R4", "level pend", 13'h200, 32'h0010_0000);
    bus_write(13'h280, 32'h0010_0000);
    rd_chk("R4", "clear while high", 13'h280, 32'h0010_0000);
    set_lvl(48'h0);
    bus_write(13'h280, 32'h0010_0000);
    rd_chk("R4", "clear low", 13'h200, 32'h0);
    bus_write(13'h204, 32'h8);
    rd_chk("R4", "set pend", 13'h204, 32'h8);
    bus_write(13'h284, 32'h8);

    // R6 arbitration
    bus_write(13'h100, 32'hFFFF_FFFF);
    bus_write(13'h104, 32'hFFFF_FFFF);
    for (int p = 0; p < 16; p++) bus_write(13'(32'h400 + 4*p), 32'h8080_8080);
    bus_write(13'h420, 32'h8080_4080);
    bus_write(13'h428, 32'h8080_8020);
    bus_write(13'h200, 32'h0010_0000);
    rd_chk("R6", "single", HPP, 32'd20);
    bus_write(13'h204, 32'h2);
    rd_chk("R6", "lower value", HPP, 32'd33);
    bus_write(13'h204, 32'h100);
    rd_chk("R6", "lowest", HPP, 32'd40);
    bus_write(13'h428, 32'h8080_2020);
    bus_write(13'h204, 32'h200);
    rd_chk("R6", "tie low id", HPP, 32'd40);
    state_chk("R6");

    // R7 forwarding gate
    bus_write(PMR, 32'hF0);
    bus_write(13'h000, 32'h1);
    idle();
    chk("R7", "cpu off irq", {31'h0, irq}, 32'h0);
    ack_chk("R7", 32'h3FF);
    bus_write(13'h000, 32'h0);
    bus_write(C, 32'h1);
    idle();
    chk("R7", "dist off irq", {31'h0, irq}, 32'h0);
    ack_chk("R7", 32'h3FF);
    bus_write(13'h000, 32'h1);
    // R12 one edge of delay
    chk("R12", "irq not yet", {31'h0, irq}, 32'h0);
    idle();
    chk("R12", "irq after edge", {31'h0, irq}, 32'h1);

    // R8 mask boundary
    bus_write(PMR, 32'h20);
    idle();
    chk("R8", "equal mask irq", {31'h0, irq}, 32'h0);
    ack_chk("R8", 32'h3FF);
    bus_write(PMR, 32'h21);
    idle();
    chk("R8", "below mask irq", {31'h0, irq}, 32'h1);

    // R9 acknowledge
    ack_chk("R9", 32'd40);
    rd_chk("R9", "active", 13'h304, 32'h100);
    rd_chk("R9", "pending", 13'h204, 32'h202);
    rd_chk("R11", "running", RPR, 32'h20);
    rd_chk("R6", "next", HPP, 32'd41);
    idle();
    chk("R11", "equal prio blocked", {31'h0, irq}, 32'h0);
    ack_chk("R11", 32'h3FF);

    // R11 nesting
    bus_write(PMR, 32'hFF);
    bus_write(13'h430, 32'h8080_8010);
    bus_write(13'h204, 32'h1_0000);
    idle();
    chk("R11", "preempt irq", {31'h0, irq}, 32'h1);
    ack_chk("R11", 32'd48);
    rd_chk("R11", "nested running", RPR, 32'h10);

    // R10 end of interrupt
    bus_write(EOI, 32'd48);
    rd_chk("R10", "after eoi 48", RPR, 32'h20);
    bus_write(EOI, 32'd100);
    rd_chk("R10", "eoi out of range", 13'h304, 32'h100);
    bus_write(EOI, 32'd40);
    rd_chk("R10", "all done", RPR, 32'hFF);
    rd_chk("R10", "next winner", HPP, 32'd41);

    // R13 software trigger
    bus_write(13'hF00, 32'h0000_0003);
    rd_chk("R13", "no target", 13'h200, 32'h0010_0000);
    bus_write(13'hF00, 32'h0001_0003);
    rd_chk("R13", "target cpu0", 13'h200, 32'h0010_0008);
    state_chk("R13");

    // random mix for R6 R8 R9 R10 R11
    for (int it = 0; it < 500; it++) begin
      case ($urandom % 11)
        0: set_lvl(48'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
        1: bus_write(13'(32'h100 + 4*($urandom % 2)), $urandom);
        2: bus_write(13'(32'h180 + 4*($urandom % 2)), $urandom);
        3: bus_write(13'(32'h400 + 4*($urandom % 16)), $urandom);
        4: bus_write(PMR, $urandom);
        5, 6: begin
          e = {22'h0, f_ack()};
          bus_read(ACK, q);
          chk("R9", "random ack", q, e);
        end
        7: bus_write(EOI, $urandom % 80);
        8: bus_write(13'(32'h200 + 4*($urandom % 2)), $urandom & $urandom);
        9: bus_write(13'(32'h280 + 4*($urandom % 2)), $urandom);
        default: bus_write(13'hF00, $urandom & 32'h0001_000F);
      endcase
      if (it % 5 == 0) state_chk("R6");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule